// File: doc/BRIEF.md
# Inter-Cluster Barrier Controller

This block lets six processing clusters meet at hardware barriers by writing to a small register window. A request on the register bus passes through three pieces of logic in one cycle. A decoder turns the address into an operation kind: control, participant mask or arrival. It also extracts the instance number and the data the operation needs. A legality checker then compares the operation with the current state. Finally an operation center updates the control bits or the per-instance registers, and it raises the release lines when a barrier fills up.

Software first sets the enable bit and loads a participant mask into one of four barrier instances. Each participating cluster then writes its own index to that instance's arrival offset. When the last expected cluster arrives, every participant sees its release line for one cycle, and the instance rearms with an empty arrived-set. An illegal operation changes no instance state. It raises a sticky error flag that software can read and clear.

The request side has no back-pressure. Every cycle in which `req_valid` is high carries one operation, and the block takes it at that clock edge. A read answers exactly one cycle later on `rsp_valid`/`rsp_rdata`. The response cannot be stalled, so the requester must be ready to take it.

Top module: `inter_cluster_barrier`

## Requirements
- R1: After reset the enable bit, the error flag, all four masks, all four arrived-sets, `release_o`, `rsp_valid` and `rsp_rdata` are zero.
- R2: A read presented in one cycle returns `rsp_valid`=1 and its data in the next cycle, and the data is the register value from before that edge. Offset 0x00 reads {error in bit 1, enable in bit 0}. Offset 0x10+4n reads instance n's mask, and 0x40+4n reads instance n's arrived-set, for n = 0..3. Any other offset reads 0, and a read never raises the error flag. When no read is answered, `rsp_valid` and `rsp_rdata` are 0.
- R3: A write to 0x00 always succeeds. Data bit 0 becomes the enable bit, a 1 in data bit 1 clears the error flag, and the other data bits are ignored.
- R4: A write to 0x10+4n stores data bits 5:0 as instance n's participant mask, whether or not the unit is enabled, provided that instance's arrived-set is empty.
- R5: A write to 0x40+4n carries a cluster index in data bits 7:0. It is legal only when the unit is enabled, the index is below 6, the cluster's bit is set in instance n's mask and that bit is not yet set in the arrived-set. A legal arrival sets that bit.
- R6: An illegal arrival, a mask write to an instance with a non-empty arrived-set, and a write to any unmapped or misaligned offset each set the sticky error flag and leave every mask and arrived-set unchanged.
- R7: When a legal arrival makes the arrived-set equal to the mask, `release_o` equals that mask for exactly the cycle after the write's edge, and the arrived-set returns to zero.
- R8: The four instances keep separate masks and arrived-sets. An operation on one instance never changes another.
- R9: Operations presented on consecutive cycles are each applied in order, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| release_o | output | 6 | One-cycle release pulse, one bit per cluster |

## Verification
A corrupted arrived-set shows up at the ports in one of two ways: a status read returns the wrong value on the following cycle, or a release pulse comes early, late or is missing when the last cluster arrives. A bad legality decision appears as an error flag that differs from expectation on the next control read. A mask that was overwritten when it should have been kept shows up on a mask read, or as the wrong set of released clusters. The bench runs a behavioural model in step with the design and compares every output on every cycle. Each fault is therefore reported in the first cycle after the operation that exposes it.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam int NCL     = 6;                 // clusters
  localparam int NINST   = 4;                 // barrier instances
  localparam int AW      = 8;                 // address width
  localparam int DW      = 32;                // data width
  localparam int IW      = $clog2(NINST);     // instance select width
  localparam int XW      = 8;                 // cluster index field width
  localparam int SHW     = $clog2(NCL) + 1;   // shift width for index one-hot
  localparam logic [AW-1:0] CTRL_OFS = 8'h00;
  localparam logic [AW-1:0] MASK_OFS = 8'h10;
  localparam logic [AW-1:0] ARRV_OFS = 8'h40;
  localparam int STRIDE  = 4;

  typedef enum logic [1:0] {OP_NONE, OP_CTRL, OP_MASK, OP_ARRIVE} op_e;

  typedef struct packed {
    logic           vld;
    logic           wr;
    op_e            op;
    logic [IW-1:0]  inst;
    logic [XW-1:0]  idx;
    logic [NCL-1:0] who;    // one-hot of idx, zero when idx out of range
    logic [NCL-1:0] mval;   // mask payload
    logic           en_v;   // control: new enable
    logic           clr_e;  // control: clear error
  } dec_t;
endpackage

// File: rtl/bar_addr_decode.sv
module bar_addr_decode
  import icb_pkg::*;
(
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output dec_t          dec
);
  localparam int SPAN = STRIDE * NINST;
  logic aligned, in_mask, in_arrv;
  logic [AW-1:0] rel_m, rel_a;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    rel_m   = addr - MASK_OFS;
    rel_a   = addr - ARRV_OFS;
    in_mask = aligned && (addr >= MASK_OFS) && (32'(rel_m) < SPAN);
    in_arrv = aligned && (addr >= ARRV_OFS) && (32'(rel_a) < SPAN);

    dec       = '0;
    dec.vld   = valid;
    dec.wr    = write;
    dec.idx   = wdata[XW-1:0];
    dec.who   = (32'(wdata[XW-1:0]) < NCL) ? (NCL'(1) << wdata[SHW-1:0]) : '0;
    dec.mval  = wdata[NCL-1:0];
    dec.en_v  = wdata[0];
    dec.clr_e = wdata[1];
    if (addr == CTRL_OFS) begin
      dec.op = OP_CTRL;
    end else if (in_mask) begin
      dec.op   = OP_MASK;
      dec.inst = rel_m[IW+1:2];
    end else if (in_arrv) begin
      dec.op   = OP_ARRIVE;
      dec.inst = rel_a[IW+1:2];
    end else begin
      dec.op = OP_NONE;
    end
  end
endmodule

// File: rtl/bar_legal_check.sv
module bar_legal_check
  import icb_pkg::*;
(
  input  dec_t           dec,
  input  logic           en,
  input  logic [NCL-1:0] mask_sel,
  input  logic [NCL-1:0] arr_sel,
  output logic           ok,    // operation forwarded to the operation center
  output logic           bad    // illegal write, raises the error flag
);
  logic legal;

  always_comb begin
    legal = 1'b1;
    if (dec.wr) begin
      unique case (dec.op)
        OP_CTRL:   legal = 1'b1;
        OP_MASK:   legal = (arr_sel == '0);
        OP_ARRIVE: legal = en && (dec.who != '0) &&
                           ((dec.who & mask_sel) != '0) &&
                           ((dec.who & arr_sel) == '0);
        default:   legal = 1'b0;
      endcase
    end
    ok  = dec.vld && legal;
    bad = dec.vld && dec.wr && !legal;
  end
endmodule

// File: rtl/bar_op_center.sv
module bar_op_center
  import icb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  dec_t           dec,
  input  logic           ok,
  input  logic           bad,
  output logic           en_q,
  output logic [NCL-1:0] mask_q [NINST],
  output logic [NCL-1:0] arr_q  [NINST],
  output logic           rsp_valid_q,
  output logic [DW-1:0]  rsp_rdata_q,
  output logic [NCL-1:0] release_q
);
  logic           err_q;
  logic [NCL-1:0] fire   [NINST];
  logic [NCL-1:0] rd_sel;
  logic [DW-1:0]  rd_val;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ok && dec.wr && dec.op == OP_CTRL) begin
        en_q <= dec.en_v;
        if (dec.clr_e) err_q <= 1'b0;
      end
      if (bad) err_q <= 1'b1;
    end
  end

  // per-instance registers
  for (genvar g = 0; g < NINST; g++) begin : g_inst
    logic hit, arr_w, msk_w;
    logic [NCL-1:0] nxt;
    always_comb begin
      hit   = ok && dec.wr && (dec.inst == IW'(g));
      arr_w = hit && dec.op == OP_ARRIVE;
      msk_w = hit && dec.op == OP_MASK;
      nxt   = arr_q[g] | dec.who;
      fire[g] = (arr_w && nxt == mask_q[g]) ? mask_q[g] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= '0;
        arr_q[g]  <= '0;
      end else begin
        if (msk_w) mask_q[g] <= dec.mval;
        if (arr_w) arr_q[g]  <= (nxt == mask_q[g]) ? '0 : nxt;
      end
    end

    assert_arr_within_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_q[g] & ~mask_q[g]) == '0);
    assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(arr_q[g]));
  end

  // release pulse and read response
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NINST; i++) rd_sel |= fire[i];
    unique case (dec.op)
      OP_CTRL:   rd_val = DW'({err_q, en_q});
      OP_MASK:   rd_val = DW'(mask_q[dec.inst]);
      OP_ARRIVE: rd_val = DW'(arr_q[dec.inst]);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      release_q   <= rd_sel;
      rsp_valid_q <= ok && !dec.wr;
      rsp_rdata_q <= (ok && !dec.wr) ? rd_val : '0;
    end
  end

  assert_release_needs_arrive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_q != '0) |-> $past(ok && dec.wr && dec.op == OP_ARRIVE));
  assert_error_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(dec.vld && dec.wr && dec.op == OP_CTRL));
  assert_bad_sets_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err_q);
endmodule

// File: rtl/inter_cluster_barrier.sv
module inter_cluster_barrier
  import icb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCL-1:0] release_o
);
  dec_t           dec;
  logic           ok, bad, en_q;
  logic [NCL-1:0] mask_q [NINST];
  logic [NCL-1:0] arr_q  [NINST];

  bar_addr_decode u_dec (
    .valid(req_valid), .write(req_write), .addr(req_addr),
    .wdata(req_wdata), .dec(dec)
  );

  bar_legal_check u_chk (
    .dec(dec), .en(en_q), .mask_sel(mask_q[dec.inst]),
    .arr_sel(arr_q[dec.inst]), .ok(ok), .bad(bad)
  );

  bar_op_center u_ctr (
    .clk(clk), .rst_n(rst_n), .dec(dec), .ok(ok), .bad(bad),
    .en_q(en_q), .mask_q(mask_q), .arr_q(arr_q),
    .rsp_valid_q(rsp_valid), .rsp_rdata_q(rsp_rdata), .release_q(release_o)
  );
endmodule

// File: tb/test_inter_cluster_barrier.sv
module test_inter_cluster_barrier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [5:0]  release_o;

  int checks = 0, fails = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R1";

  inter_cluster_barrier i_inter_cluster_barrier (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .release_o(release_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  // behavioural reference model
  logic       m_en, m_err;
  logic [5:0] m_mask [4];
  logic [5:0] m_arr  [4];
  logic [5:0] e_rel;
  logic       e_rv;
  logic [31:0] e_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_err = 0; e_rel = 0; e_rv = 0; e_rd = 0;
      for (int i = 0; i < 4; i++) begin m_mask[i] = 0; m_arr[i] = 0; end
    end else begin
      int a, k, idx;
      bit is_c, is_m, is_a;
      e_rel = 0; e_rv = 0; e_rd = 0;
      if (req_valid) begin
        a = req_addr; k = (a >> 2) & 3;
        is_c = (a == 0);
        is_m = (a % 4 == 0) && a >= 16 && a < 32;
        is_a = (a % 4 == 0) && a >= 64 && a < 80;
        if (!req_write) begin
          e_rv = 1;
          if (is_c) e_rd = {30'd0, m_err, m_en};
          else if (is_m) e_rd = {26'd0, m_mask[k]};
          else if (is_a) e_rd = {26'd0, m_arr[k]};
        end else if (is_c) begin
          m_en = req_wdata[0];
          if (req_wdata[1]) m_err = 0;
        end else if (is_m) begin
          if (m_arr[k] == 0) m_mask[k] = req_wdata[5:0]; else m_err = 1;
        end else if (is_a) begin
          idx = req_wdata[7:0];
          if (m_en && idx < 6 && m_mask[k][idx] && !m_arr[k][idx]) begin
            m_arr[k][idx] = 1'b1;
            if (m_arr[k] == m_mask[k]) begin e_rel = m_mask[k]; m_arr[k] = 0; end
          end else m_err = 1;
        end else m_err = 1;
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (release_o !== e_rel || rsp_valid !== e_rv || rsp_rdata !== e_rd) begin
        fails++;
        $display("FAIL %s: rel=%b rv=%b rd=%h expected rel=%b rv=%b rd=%h",
                 cur_req, release_o, rsp_valid, rsp_rdata, e_rel, e_rv, e_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic op(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
  endtask
  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (n) @(negedge clk);
  endtask
  task automatic rd(input logic [7:0] a); op(0, a, 0); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); op(1, a, d); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
    cur_req = "R1"; idle(2); rd(8'h00); rd(8'h10); rd(8'h4C); rd(8'h1C); idle(1);
    cur_req = "R2"; rd(8'h08); rd(8'h30); rd(8'h11); idle(1);
    cur_req = "R5"; wr(8'h10, 32'h3F); wr(8'h40, 0); idle(1); rd(8'h40); rd(8'h00); idle(1);
    cur_req = "R3"; wr(8'h00, 32'hFFFF_FFF2); rd(8'h00); wr(8'h00, 32'h3); rd(8'h00); idle(1);
    cur_req = "R4"; wr(8'h14, 32'hFFFF_FFE5); wr(8'h18, 32'h20); rd(8'h14); rd(8'h18); idle(1);
    cur_req = "R5"; wr(8'h40, 2); wr(8'h40, 0); rd(8'h40); idle(1);
    cur_req = "R6"; wr(8'h40, 2); rd(8'h00); wr(8'h00, 3);
    wr(8'h40, 6); wr(8'h40, 32'h100); wr(8'h44, 1); rd(8'h44); wr(8'h10, 1); rd(8'h10);
    wr(8'h20, 1); wr(8'h41, 1); wr(8'h50, 1); rd(8'h40); rd(8'h00); wr(8'h00, 3); idle(1);
    cur_req = "R7"; wr(8'h40, 1); wr(8'h40, 3); wr(8'h40, 4); idle(1); wr(8'h40, 5); idle(2);
    rd(8'h40); idle(1);
    cur_req = "R8"; wr(8'h44, 0); wr(8'h48, 5); wr(8'h44, 2); rd(8'h44); rd(8'h48); idle(1);
    wr(8'h10, 32'h11); wr(8'h40, 4); wr(8'h4C, 0); rd(8'h40); rd(8'h1C); idle(1);
    cur_req = "R9"; wr(8'h00, 0); wr(8'h40, 0); wr(8'h00, 3); wr(8'h40, 0); rd(8'h40); rd(8'h00);
    wr(8'h1C, 3); wr(8'h4C, 1); wr(8'h4C, 0); rd(8'h4C); idle(3);
    chk_on = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule